// File: doc/BRIEF.md
# Configuration-Header Identity Loader

This block sets up the read-only identity fields of a PCI configuration header from a serial configuration EEPROM. After reset it fetches words from the EEPROM on its own, through a word-read port that uses a request and acknowledge handshake. It first checks a signature and some option bits in word 0xA. From these it decides whether the EEPROM is valid, whether subsystem identities are loaded from words 0xB and 0xC, whether the low revision bits are overridden, and whether the alternate device ID is used.

A simple dword-indexed configuration port sits next to the loader. Until the load is finished, every access on this port gets a Retry response with no data. After that, reads return the header layout and writes can update the Interrupt Line register. A reset brings the block back to the retry state and starts the load again.

Top module: `pci_id_loader`

## Requirements
- R1: The first EEPROM word requested is address 0xA. Words 0xB and then 0xC are requested only when word 0xA has bits 15:14 equal to 01b and bit 13 equal to 1. In all other cases no further word is requested.
- R2: Any configuration access whose request cycle falls before `load_done_o` is high gets a response with `cfg_retry_o`=1, `cfg_ack_o`=0 and `cfg_rdata_o`=0.
- R3: `load_done_o` rises in the cycle after the acknowledge of the last word needed: one word for the short load, three for the extended load. `ee_req_o` is high exactly while `load_done_o` is low.
- R4: When bits 15:14 of word 0xA are not 01b, the identity fields keep their defaults: Device ID 1229h, Revision ID equal to REV_ID, and Subsystem ID and Subsystem Vendor ID equal to 0000h.
- R5: Under the extended condition (signature 01b and bit 13 = 1), Subsystem ID equals word 0xB and Subsystem Vendor ID equals word 0xC. Otherwise both read as 0000h.
- R6: Under the extended condition, Revision ID bits 2:0 are taken from word 0xA bits 10:8, and bits 7:3 stay at REV_ID.
- R7: Device ID is 1029h only under the extended condition with word 0xA bit 7 = 0. In every other case it is 1229h.
- R8: Vendor ID always equals the VENDOR_ID parameter (default 8086h), whatever the EEPROM holds.
- R9: A read of index 0 returns {Device ID, Vendor ID}. Index 2 returns Revision ID in bits 7:0. Index 0xB returns {Subsystem ID, Subsystem Vendor ID}. Index 0xD returns DCh in bits 7:0. Index 0xF returns {Max_Lat (default 00h), Min_Gnt 08h, Interrupt Pin 01h, Interrupt Line}.
- R10: A write to index 0xF after the load stores wdata bits 7:0 as Interrupt Line. A write that gets Retry leaves Interrupt Line unchanged.
- R11: A read of any other index returns 0.
- R12: When reset is asserted during a load, `load_done_o` is cleared. When reset is released, the load starts again from address 0xA.
- R13: Each access gets exactly one response cycle, with either `cfg_ack_o` or `cfg_retry_o` set, one cycle after its request cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_req_o | output | 1 | EEPROM word-read request |
| ee_addr_o | output | EE_AW | EEPROM word address |
| ee_ack_i | input | 1 | EEPROM word valid (one-cycle pulse) |
| ee_data_i | input | 16 | EEPROM word data |
| load_done_o | output | 1 | Identity load finished |
| cfg_valid_i | input | 1 | Configuration access request |
| cfg_write_i | input | 1 | 1 = write, 0 = read |
| cfg_idx_i | input | IDX_W | Dword index |
| cfg_wdata_i | input | 32 | Write data |
| cfg_ack_o | output | 1 | Access completed |
| cfg_retry_o | output | 1 | Access must be retried |
| cfg_rdata_o | output | 32 | Read data |

## Verification
The loader is exercised with word 0xA set to each signature value (00b, 01b, 10b and 11b). These runs separate the single valid code from the three fallback codes, and they show that bit 15 on its own forces the defaults. With the signature valid, bits 13 and 7 are toggled independently and the word 0xA bits 10:8 are set to a non-zero value. This separates the subsystem load, the alternate device ID and the revision override, so that a swapped or merged condition becomes visible. A reset during a load, and accesses issued every other cycle while the load is running, show that the retry window ends exactly at `load_done_o` and that the fetch starts again from 0xA.

// File: rtl/pci_id_pkg.sv
package pci_id_pkg;
  localparam int unsigned EE_DW = 16;

  typedef enum logic [1:0] {FS_WA, FS_WB, FS_WC, FS_DONE} fetch_st_e;

  typedef struct packed {
    logic [15:0] dev_id;
    logic [7:0]  rev_id;
    logic [15:0] sub_id;
    logic [15:0] sub_vid;
  } id_fields_t;
endpackage

// File: rtl/id_fetch_seq.sv
module id_fetch_seq
  import pci_id_pkg::*;
#(
  parameter int unsigned EE_AW  = 6,
  parameter int unsigned ADDR_A = 'hA,
  parameter int unsigned ADDR_B = 'hB,
  parameter int unsigned ADDR_C = 'hC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  input  logic             ee_ack_i,
  input  logic [EE_DW-1:0] ee_data_i,
  output logic [EE_DW-1:0] word_a_o,
  output logic [EE_DW-1:0] word_b_o,
  output logic [EE_DW-1:0] word_c_o,
  output logic             done_o
);
  fetch_st_e        state_q;
  logic [EE_DW-1:0] word_a_q, word_b_q, word_c_q;
  logic             more_words;

  // extended load needs words B and C
  assign more_words = (ee_data_i[15:14] == 2'b01) && ee_data_i[13];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FS_WA;
      word_a_q <= '0;
      word_b_q <= '0;
      word_c_q <= '0;
    end else if (ee_ack_i) begin
      unique case (state_q)
        FS_WA: begin
          word_a_q <= ee_data_i;
          state_q  <= more_words ? FS_WB : FS_DONE;
        end
        FS_WB: begin
          word_b_q <= ee_data_i;
          state_q  <= FS_WC;
        end
        FS_WC: begin
          word_c_q <= ee_data_i;
          state_q  <= FS_DONE;
        end
        default: state_q <= FS_DONE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      FS_WB:   ee_addr_o = EE_AW'(ADDR_B);
      FS_WC:   ee_addr_o = EE_AW'(ADDR_C);
      default: ee_addr_o = EE_AW'(ADDR_A);
    endcase
  end

  assign ee_req_o = (state_q != FS_DONE);
  assign done_o   = (state_q == FS_DONE);
  assign word_a_o = word_a_q;
  assign word_b_o = word_b_q;
  assign word_c_o = word_c_q;

  p_ext_path_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_req_o && ee_addr_o == EE_AW'(ADDR_B)) |-> (word_a_q[15:13] == 3'b011));
  p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_word_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(word_a_q) && $stable(word_b_q) && $stable(word_c_q)));
endmodule

// File: rtl/id_field_decode.sv
module id_field_decode
  import pci_id_pkg::*;
#(
  parameter logic [15:0] DEV_ID     = 16'h1229,
  parameter logic [15:0] ALT_DEV_ID = 16'h1029,
  parameter logic [7:0]  REV_ID     = 8'h08
) (
  input  logic [EE_DW-1:0] word_a_i,
  input  logic [EE_DW-1:0] word_b_i,
  input  logic [EE_DW-1:0] word_c_i,
  output id_fields_t       fields_o
);
  logic sig_ok, ext;

  assign sig_ok = (word_a_i[15:14] == 2'b01);
  assign ext    = sig_ok && word_a_i[13];

  always_comb begin
    fields_o.dev_id  = (ext && !word_a_i[7]) ? ALT_DEV_ID : DEV_ID;
    fields_o.rev_id  = ext ? {REV_ID[7:3], word_a_i[10:8]} : REV_ID;
    fields_o.sub_id  = ext ? word_b_i : 16'h0000;
    fields_o.sub_vid = ext ? word_c_i : 16'h0000;
  end
endmodule

// File: rtl/cfg_hdr_port.sv
module cfg_hdr_port
  import pci_id_pkg::*;
#(
  parameter int unsigned IDX_W     = 6,
  parameter logic [15:0] VENDOR_ID = 16'h8086,
  parameter logic [7:0]  CAP_PTR   = 8'hDC,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  parameter logic [7:0]  MIN_GNT   = 8'h08,
  parameter logic [7:0]  MAX_LAT   = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_done_i,
  input  id_fields_t       fields_i,
  input  logic             cfg_valid_i,
  input  logic             cfg_write_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic             cfg_ack_o,
  output logic             cfg_retry_o,
  output logic [31:0]      cfg_rdata_o
);
  localparam logic [IDX_W-1:0] IDX_ID   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_REV  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_SUB  = IDX_W'(11);
  localparam logic [IDX_W-1:0] IDX_CAP  = IDX_W'(13);
  localparam logic [IDX_W-1:0] IDX_INTR = IDX_W'(15);

  logic        ack_q, retry_q, accept, line_we;
  logic [31:0] rdata_q, rd_mux;
  logic [7:0]  int_line_q;

  assign accept  = cfg_valid_i && load_done_i;
  assign line_we = accept && cfg_write_i && (cfg_idx_i == IDX_INTR);

  always_comb begin
    rd_mux = '0;
    if (cfg_idx_i == IDX_ID)        rd_mux = {fields_i.dev_id, VENDOR_ID};
    else if (cfg_idx_i == IDX_REV)  rd_mux = {24'h0, fields_i.rev_id};
    else if (cfg_idx_i == IDX_SUB)  rd_mux = {fields_i.sub_id, fields_i.sub_vid};
    else if (cfg_idx_i == IDX_CAP)  rd_mux = {24'h0, CAP_PTR};
    else if (cfg_idx_i == IDX_INTR) rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      retry_q    <= 1'b0;
      rdata_q    <= '0;
      int_line_q <= '0;
    end else begin
      ack_q   <= accept;
      retry_q <= cfg_valid_i && !load_done_i;
      rdata_q <= (accept && !cfg_write_i) ? rd_mux : '0;
      if (line_we) int_line_q <= cfg_wdata_i[7:0];
    end
  end

  assign cfg_ack_o   = ack_q;
  assign cfg_retry_o = retry_q;
  assign cfg_rdata_o = rdata_q;

  p_retry_early_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && !load_done_i) |=> (cfg_retry_o && !cfg_ack_o && cfg_rdata_o == '0));
  p_one_resp_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_ack_o && cfg_retry_o));
  p_no_spurious_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> (!cfg_ack_o && !cfg_retry_o));
  p_line_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_valid_i && cfg_write_i && load_done_i) |=> $stable(int_line_q));
endmodule

// File: rtl/pci_id_loader.sv
module pci_id_loader
  import pci_id_pkg::*;
#(
  parameter int unsigned EE_AW      = 6,
  parameter int unsigned IDX_W      = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [15:0] DEV_ID     = 16'h1229,
  parameter logic [15:0] ALT_DEV_ID = 16'h1029,
  parameter logic [7:0]  REV_ID     = 8'h08,
  parameter logic [7:0]  MAX_LAT    = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  input  logic             ee_ack_i,
  input  logic [15:0]      ee_data_i,
  output logic             load_done_o,
  input  logic             cfg_valid_i,
  input  logic             cfg_write_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic             cfg_ack_o,
  output logic             cfg_retry_o,
  output logic [31:0]      cfg_rdata_o
);
  logic [EE_DW-1:0] word_a, word_b, word_c;
  logic             done;
  id_fields_t       fields;

  id_fetch_seq #(.EE_AW(EE_AW)) i_fetch (
    .clk_i, .rst_ni, .ee_req_o, .ee_addr_o, .ee_ack_i, .ee_data_i,
    .word_a_o(word_a), .word_b_o(word_b), .word_c_o(word_c), .done_o(done)
  );

  id_field_decode #(.DEV_ID(DEV_ID), .ALT_DEV_ID(ALT_DEV_ID), .REV_ID(REV_ID)) i_decode (
    .word_a_i(word_a), .word_b_i(word_b), .word_c_i(word_c), .fields_o(fields)
  );

  cfg_hdr_port #(.IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID), .MAX_LAT(MAX_LAT)) i_port (
    .clk_i, .rst_ni, .load_done_i(done), .fields_i(fields),
    .cfg_valid_i, .cfg_write_i, .cfg_idx_i, .cfg_wdata_i,
    .cfg_ack_o, .cfg_retry_o, .cfg_rdata_o
  );

  assign load_done_o = done;

  p_req_vs_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_req_o != load_done_o);
endmodule

// File: tb/test_pci_id_loader.sv
module test_pci_id_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ee_req_o, ee_ack_i;
  logic [5:0]  ee_addr_o;
  logic [15:0] ee_data_i;
  logic        load_done_o;
  logic        cfg_valid_i = 1'b0, cfg_write_i = 1'b0;
  logic [5:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        cfg_ack_o, cfg_retry_o;
  logic [31:0] cfg_rdata_o;

  int checks = 0, failures = 0;
  logic [15:0] mem_a, mem_b, mem_c;
  int acks, need;
  int ee_cnt;

  always #4 clk_i = ~clk_i;

  pci_id_loader i_pci_id_loader (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ee_word(logic [5:0] a);
    if (a == 6'hA) return mem_a;
    if (a == 6'hB) return mem_b;
    if (a == 6'hC) return mem_c;
    return 16'hFFFF;
  endfunction

  // EEPROM responder: ack three cycles into a request
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ee_ack_i <= 1'b0; ee_data_i <= '0; ee_cnt <= 0;
    end else if (ee_req_o && !ee_ack_i) begin
      if (ee_cnt == 2) begin
        ee_ack_i <= 1'b1; ee_data_i <= ee_word(ee_addr_o); ee_cnt <= 0;
      end else ee_cnt <= ee_cnt + 1;
    end else ee_ack_i <= 1'b0;
  end

  // reference model: fetch order and completion point
  function automatic bit is_ext(logic [15:0] a);
    return a[15:14] == 2'b01 && a[13] == 1'b1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acks <= 0;
    else if (ee_ack_i) begin
      chk("R1 fetch address", 32'(ee_addr_o), (acks == 0) ? 32'hA : (acks == 1) ? 32'hB : 32'hC);
      acks <= acks + 1;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    chk("R3 load_done", 32'(load_done_o), 32'(acks >= need));
    chk("R3 ee_req", 32'(ee_req_o), 32'(acks < need));
  end

  task automatic cfg_acc(input logic wr, input logic [5:0] idx, input logic [31:0] wd,
                         output logic ack, output logic rty, output logic [31:0] rd);
    @(negedge clk_i);
    cfg_valid_i = 1'b1; cfg_write_i = wr; cfg_idx_i = idx; cfg_wdata_i = wd;
    @(negedge clk_i);
    cfg_valid_i = 1'b0; cfg_write_i = 1'b0;
    ack = cfg_ack_o; rty = cfg_retry_o; rd = cfg_rdata_o;
  endtask

  task automatic rd_chk(string req, logic [5:0] idx, logic [31:0] exp);
    logic a, r; logic [31:0] d;
    cfg_acc(1'b0, idx, '0, a, r, d);
    chk({req, " ack"}, 32'({a, r}), 32'b10);
    chk({req, " data"}, d, exp);
  endtask

  task automatic run(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [7:0] line);
    logic ak, rt; logic [31:0] d;
    logic [15:0] dev, ssid, ssvid; logic [7:0] rev;
    mem_a = a; mem_b = b; mem_c = c;
    need = is_ext(a) ? 3 : 1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R12 done cleared in reset", 32'(load_done_o), 32'h0);
    rst_ni = 1'b1;
    // accesses during the load: retry; write attempt must not land
    cfg_acc(1'b1, 6'hF, 32'h55, ak, rt, d);
    chk("R2 R10 retry on early write", 32'({ak, rt}), 32'b01);
    while (!load_done_o) begin
      cfg_acc(1'b0, 6'h0, '0, ak, rt, d);
      if (rt) chk("R2 retry data zero", d, 32'h0);
      else    chk("R13 one response", 32'(ak), 32'h1);
    end
    dev   = (is_ext(a) && !a[7]) ? 16'h1029 : 16'h1229;
    rev   = is_ext(a) ? {5'b00001, a[10:8]} : 8'h08;
    ssid  = is_ext(a) ? b : 16'h0;
    ssvid = is_ext(a) ? c : 16'h0;
    rd_chk("R7 R8 idx0", 6'h0, {dev, 16'h8086});
    rd_chk("R6 R4 idx2", 6'h2, {24'h0, rev});
    rd_chk("R5 idx0B", 6'hB, {ssid, ssvid});
    rd_chk("R9 cap", 6'hD, 32'h000000DC);
    rd_chk("R10 line after reset", 6'hF, 32'h00080100);
    cfg_acc(1'b1, 6'hF, {24'hABCDEF, line}, ak, rt, d);
    chk("R13 write ack", 32'({ak, rt}), 32'b10);
    rd_chk("R9 R10 idx0F", 6'hF, {16'h0008, 8'h01, line});
    rd_chk("R11 unmapped 5", 6'h5, 32'h0);
    rd_chk("R11 unmapped 3F", 6'h3F, 32'h0);
    @(negedge clk_i);
    chk("R13 idle no response", 32'({cfg_ack_o, cfg_retry_o}), 32'b00);
  endtask

  initial begin
    need = 1;
    mem_a = '0; mem_b = '0; mem_c = '0;
    repeat (2) @(negedge clk_i);
    chk("R2 reset ack/retry", 32'({cfg_ack_o, cfg_retry_o}), 32'b00);
    run(16'h6500, 16'h1234, 16'h5678, 8'h0B); // ext, alt dev, rev 5
    run(16'h6580, 16'hAAAA, 16'h5555, 8'h21); // ext, bit7 set
    run(16'h4700, 16'h1111, 16'h2222, 8'h03); // sig ok, no bit13
    run(16'hE780, 16'h3333, 16'h4444, 8'h07); // sig 11
    run(16'hA700, 16'h3333, 16'h4444, 8'h09); // sig 10, bit15
    run(16'h2700, 16'h3333, 16'h4444, 8'h0A); // sig 00
    // R12: reset in mid-load restarts fetch from 0xA
    mem_a = 16'h6200; mem_b = 16'hBEEF; mem_c = 16'hCAFE; need = 3;
    rst_ni = 1'b0; repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R12 req restarts", 32'({ee_req_o, load_done_o}), 32'b10);
    run(16'h6200, 16'hBEEF, 16'hCAFE, 8'h44);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule